// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This controller steps a system-on-chip between six ordered power modes. A one-cycle request carries a target mode; starting from Active, the sequencer first asks the external memory controller to put memory into self-refresh, waits for that acknowledge, gates the main oscillator, and only then drops the per-domain power enables and lowers the supply-select levels to the pattern of the target mode. A wakeup pulse replays these steps in reverse order and ends in Active.

The four domains are wakeup, processor, peripheral and graphics. For each one the block reports a power status and a memory status, so software or a neighbouring block can see which memories are live, retained or lost. If the memory controller never acknowledges, a programmable cycle limit abandons the entry and raises a sticky error flag. Requests that arrive while the block is busy, or while it sits in a low-power mode, are held and served once the block is back in a stable Active state.

Top module: `lps_sequencer`

## Requirements
- R1: After reset the block reports Active (mode 5), with all four domain enables high, the oscillator enable high, both supply selects at nominal (2'b10), the self-refresh request low, busy low and the error flag low.
- R2: Mode codes are 0 RTC-only, 1 deep sleep 0, 2 deep sleep 1, 3 deep sleep 2, 4 standby and 5 Active, in rising power order. A request for code 6 or 7 is ignored.
- R3: In a stable mode the outputs follow this table. Domain enable bits are [0] wakeup, [1] processor, [2] peripheral and [3] graphics. Supply select codes are 00 off, 01 reduced and 10 nominal. RTC gives 0000 / oscillator off / 00. DS0 gives 0001 / off / 01. DS1 gives 0101 / off / 01. DS2 gives 0101 / on / 01. Standby gives 0111 / on / 10. Active gives 1111 / on / 10.
- R4: On entry, the self-refresh request rises first, while the oscillator and the domains stay untouched until the acknowledge is seen. The oscillator is gated in the next cycle, and the domains and supplies switch in the cycle after that.
- R5: The self-refresh request stays high for as long as the block is in any mode other than Active.
- R6: On wakeup, the domains and supplies return to the Active levels first, while the oscillator and the self-refresh request stay as they were. The oscillator is enabled one cycle later, and the self-refresh request is released one cycle after that. Active is reported once the acknowledge has dropped.
- R7: In RTC-only mode the wakeup input has no effect, and only reset leaves that mode.
- R8: A valid request that arrives while the block is busy or in a low-power mode is held, and the latest such request wins. It is started on the first cycle the block is stable in Active.
- R9: When no acknowledge has been seen after `timeout_i` cycles of waiting, the entry is abandoned. The self-refresh request is dropped, the block returns to Active and the error flag is set. The flag clears when the next entry starts.
- R10: Status uses two bits per domain at bits [2i+1:2i], in the same domain order as the enables. Power status is 11 when the domain is on and 00 when it is off. Memory status is 11 when the domain is on, 01 (retention) when it is off but its supply is not off, and 00 when its supply is off.
- R11: A request for Active while the block is already stable in Active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| wake_i | input | 1 | Wakeup event |
| sr_ack_i | input | 1 | Self-refresh acknowledge from memory controller |
| timeout_i | input | TW (8) | Acknowledge wait limit in cycles, at least 1 |
| sr_req_o | output | 1 | Self-refresh request to memory controller |
| osc_en_o | output | 1 | Main oscillator enable |
| dom_en_o | output | 4 | Domain power enables |
| core_sel_o | output | 2 | Core supply select |
| mpu_sel_o | output | 2 | Processor supply select |
| mode_o | output | 3 | Current stable mode |
| busy_o | output | 1 | Transition in progress |
| err_o | output | 1 | Sticky acknowledge-timeout flag |
| pwr_st_o | output | 8 | Per-domain power status |
| mem_st_o | output | 8 | Per-domain memory status |

## Verification
The hardest situations to reach are the held request and the timeout boundary. For the first, a second request has to arrive in the middle of an entry, and the bench then has to watch that request start on its own right after the following wakeup. For the second, the bench's memory model acknowledges exactly three cycles after the request. Limits of 2 and 3 then fall on either side of the acknowledge, so one run aborts and the other completes. The bench also samples the first two cycles after each wakeup pulse to catch any reordering of the restore steps.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int NDOM    = 4;
    localparam int DOM_MPU = 1;

    typedef enum logic [2:0] {
        MD_RTC  = 3'd0,
        MD_DS0  = 3'd1,
        MD_DS1  = 3'd2,
        MD_DS2  = 3'd3,
        MD_STBY = 3'd4,
        MD_ACT  = 3'd5
    } mode_e;

    localparam logic [1:0] SUP_OFF = 2'b00;
    localparam logic [1:0] SUP_RED = 2'b01;
    localparam logic [1:0] SUP_NOM = 2'b10;

    localparam logic [1:0] ST_OFF = 2'b00;
    localparam logic [1:0] ST_RET = 2'b01;
    localparam logic [1:0] ST_ON  = 2'b11;

    typedef struct packed {
        logic [NDOM-1:0] dom;
        logic            osc;
        logic [1:0]      sel;
    } pattern_t;

    // Domain bits: [0] wakeup, [1] processor, [2] peripheral, [3] graphics
    function automatic pattern_t mode_pattern(mode_e m);
        pattern_t p;
        p = '{dom: 4'b1111, osc: 1'b1, sel: SUP_NOM};
        case (m)
            MD_RTC:  p = '{dom: 4'b0000, osc: 1'b0, sel: SUP_OFF};
            MD_DS0:  p = '{dom: 4'b0001, osc: 1'b0, sel: SUP_RED};
            MD_DS1:  p = '{dom: 4'b0101, osc: 1'b0, sel: SUP_RED};
            MD_DS2:  p = '{dom: 4'b0101, osc: 1'b1, sel: SUP_RED};
            MD_STBY: p = '{dom: 4'b0111, osc: 1'b1, sel: SUP_NOM};
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lps_pattern.sv
module lps_pattern
    import lps_pkg::*;
(
    input  mode_e    mode_i,
    output pattern_t pat_o
);
    always_comb pat_o = mode_pattern(mode_i);
endmodule

// File: rtl/lps_timer.sv
module lps_timer #(
    parameter int TW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [TW-1:0] cnt_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lps_status.sv
module lps_status
    import lps_pkg::*;
(
    input  logic [NDOM-1:0]   dom_i,
    input  logic [1:0]        csel_i,
    input  logic [1:0]        msel_i,
    output logic [2*NDOM-1:0] pwr_o,
    output logic [2*NDOM-1:0] mem_o
);
    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        logic [1:0] sel;
        assign sel = (i == DOM_MPU) ? msel_i : csel_i;
        assign pwr_o[2*i +: 2] = dom_i[i] ? ST_ON : ST_OFF;
        assign mem_o[2*i +: 2] = dom_i[i] ? ST_ON :
                                 ((sel == SUP_OFF) ? ST_OFF : ST_RET);
    end
endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
    import lps_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [2:0]        req_mode_i,
    input  logic              wake_i,
    input  logic              sr_ack_i,
    input  logic [TW-1:0]     timeout_i,
    output logic              sr_req_o,
    output logic              osc_en_o,
    output logic [NDOM-1:0]   dom_en_o,
    output logic [1:0]        core_sel_o,
    output logic [1:0]        mpu_sel_o,
    output logic [2:0]        mode_o,
    output logic              busy_o,
    output logic              err_o,
    output logic [2*NDOM-1:0] pwr_st_o,
    output logic [2*NDOM-1:0] mem_st_o
);
    localparam logic [NDOM-1:0] ALL_ON = '1;

    typedef enum logic [2:0] {
        S_STABLE, S_ENT_WAIT, S_ENT_OSC, S_ENT_DOM, S_WK_OSC, S_WK_SR, S_WK_ACK
    } state_e;

    typedef struct packed {
        state_e          st;
        mode_e           mode;
        mode_e           tgt;
        logic            sr_req;
        logic            osc;
        logic [NDOM-1:0] dom;
        logic [1:0]      csel;
        logic [1:0]      msel;
        logic            err;
        logic            pend;
        mode_e           pmode;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        st: S_STABLE, mode: MD_ACT, tgt: MD_ACT, sr_req: 1'b0, osc: 1'b1,
        dom: ALL_ON, csel: SUP_NOM, msel: SUP_NOM, err: 1'b0,
        pend: 1'b0, pmode: MD_ACT
    };

    seq_s          d, q;
    pattern_t      pat;
    logic [TW-1:0] wait_cnt;
    logic          req_ok;
    logic          stable_act;

    lps_pattern u_pat (
        .mode_i (q.tgt),
        .pat_o  (pat)
    );

    lps_timer #(.TW(TW)) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (q.st != S_ENT_WAIT),
        .inc_i  (q.st == S_ENT_WAIT),
        .cnt_o  (wait_cnt)
    );

    lps_status u_st (
        .dom_i  (q.dom),
        .csel_i (q.csel),
        .msel_i (q.msel),
        .pwr_o  (pwr_st_o),
        .mem_o  (mem_st_o)
    );

    assign req_ok     = req_valid_i && (req_mode_i <= 3'd5);
    assign stable_act = (q.st == S_STABLE) && (q.mode == MD_ACT);

    always_comb begin
        d = q;
        // Hold requests that cannot be served now
        if (req_ok && !stable_act) begin
            d.pend  = 1'b1;
            d.pmode = mode_e'(req_mode_i);
        end
        case (q.st)
            S_STABLE: begin
                if (q.mode == MD_ACT) begin
                    if (req_ok || q.pend) begin
                        d.pend = 1'b0;
                        d.tgt  = req_ok ? mode_e'(req_mode_i) : q.pmode;
                        if (d.tgt != MD_ACT) begin
                            d.sr_req = 1'b1;
                            d.err    = 1'b0;
                            d.st     = S_ENT_WAIT;
                        end
                    end
                end else if (q.mode != MD_RTC && wake_i) begin
                    d.dom  = ALL_ON;
                    d.csel = SUP_NOM;
                    d.msel = SUP_NOM;
                    d.st   = S_WK_OSC;
                end
            end
            S_ENT_WAIT: begin
                if (sr_ack_i) begin
                    d.st = S_ENT_OSC;
                end else if (wait_cnt == timeout_i - TW'(1)) begin
                    d.sr_req = 1'b0;
                    d.err    = 1'b1;
                    d.st     = S_WK_ACK;
                end
            end
            S_ENT_OSC: begin
                d.osc = pat.osc;
                d.st  = S_ENT_DOM;
            end
            S_ENT_DOM: begin
                d.dom  = pat.dom;
                d.csel = pat.sel;
                d.msel = pat.sel;
                d.mode = q.tgt;
                d.st   = S_STABLE;
            end
            S_WK_OSC: begin
                d.osc = 1'b1;
                d.st  = S_WK_SR;
            end
            S_WK_SR: begin
                d.sr_req = 1'b0;
                d.st     = S_WK_ACK;
            end
            S_WK_ACK: begin
                if (!sr_ack_i) begin
                    d.mode = MD_ACT;
                    d.st   = S_STABLE;
                end
            end
            default: d.st = S_STABLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= SEQ_RST;
        else         q <= d;
    end

    assign sr_req_o   = q.sr_req;
    assign osc_en_o   = q.osc;
    assign dom_en_o   = q.dom;
    assign core_sel_o = q.csel;
    assign mpu_sel_o  = q.msel;
    assign mode_o     = q.mode;
    assign busy_o     = (q.st != S_STABLE);
    assign err_o      = q.err;

    AST_STABLE_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == S_STABLE) |-> (q.dom == mode_pattern(q.mode).dom)); // R3
    AST_DOM_OFF_UNDER_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.dom != ALL_ON) |-> q.sr_req); // R4
    AST_OSC_GATE_AFTER_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.osc) |-> $past(q.sr_req)); // R4
    AST_SR_HELD_LOW_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == S_STABLE && q.mode != MD_ACT) |-> q.sr_req); // R5
    AST_WAKE_OSC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.osc) |-> (q.dom == ALL_ON && q.sr_req)); // R6
    AST_RTC_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == S_STABLE && q.mode == MD_RTC) |=> (q.mode == MD_RTC)); // R7
    AST_ABORT_TO_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.err) |-> (q.dom == ALL_ON && q.osc && !q.sr_req)); // R9
endmodule

// File: tb/tb_lps_sequencer.sv
module tb_lps_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = 3'd0;
    logic       wake = 1'b0;
    logic       sr_ack = 1'b0;
    logic [7:0] timeout = 8'd20;
    logic       mem_ok = 1'b1;
    logic       ack_d1 = 1'b0;

    logic       sr_req, osc_en, busy, err;
    logic [3:0] dom_en;
    logic [1:0] core_sel, mpu_sel;
    logic [2:0] mode;
    logic [7:0] pwr_st, mem_st;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // Memory controller model: acknowledge follows request by two registers
    always @(posedge clk) begin
        ack_d1 <= sr_req & mem_ok;
        sr_ack <= ack_d1;
    end

    lps_sequencer #(.TW(8)) dut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
        .wake_i(wake), .sr_ack_i(sr_ack), .timeout_i(timeout),
        .sr_req_o(sr_req), .osc_en_o(osc_en), .dom_en_o(dom_en),
        .core_sel_o(core_sel), .mpu_sel_o(mpu_sel), .mode_o(mode),
        .busy_o(busy), .err_o(err), .pwr_st_o(pwr_st), .mem_st_o(mem_st)
    );

    // {mode, dom, osc, sel, mem status}, indexed by mode code
    localparam logic [17:0] VEC [0:5] = '{
        {3'd0, 4'b0000, 1'b0, 2'b00, 8'h00},
        {3'd1, 4'b0001, 1'b0, 2'b01, 8'h57},
        {3'd2, 4'b0101, 1'b0, 2'b01, 8'h77},
        {3'd3, 4'b0101, 1'b1, 2'b01, 8'h77},
        {3'd4, 4'b0111, 1'b1, 2'b10, 8'h7F},
        {3'd5, 4'b1111, 1'b1, 2'b10, 8'hFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pwr_of(input logic [3:0] dm);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) r[2*i +: 2] = dm[i] ? 2'b11 : 2'b00;
        return r;
    endfunction

    task automatic chk_mode(input int idx, input string tag);
        logic [17:0] v;
        v = VEC[idx];
        chk({tag, " mode"}, 32'(mode), 32'(v[17:15]));
        chk({tag, " dom"}, 32'(dom_en), 32'(v[14:11]));
        chk({tag, " osc"}, 32'(osc_en), 32'(v[10]));
        chk({tag, " core_sel"}, 32'(core_sel), 32'(v[9:8]));
        chk({tag, " mpu_sel"}, 32'(mpu_sel), 32'(v[9:8]));
        chk({tag, " R10 mem"}, 32'(mem_st), 32'(v[7:0]));
        chk({tag, " R10 pwr"}, 32'(pwr_st), 32'(pwr_of(v[14:11])));
    endtask

    task automatic pulse_req(input logic [2:0] m);
        @(negedge clk); req_valid = 1'b1; req_mode = m;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        for (int k = 0; k < 64 && busy; k++) @(negedge clk);
        chk({tag, " settle"}, 32'(busy), 32'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mode(5, "R1");
        chk("R1 sr_req", 32'(sr_req), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 err", 32'(err), 0);

        pulse_req(3'd5);
        chk("R11 busy", 32'(busy), 0);
        pulse_req(3'd7);
        chk("R2 invalid code", 32'(busy), 0);
        chk("R2 mode kept", 32'(mode), 5);

        // Table walk over DS0..standby
        for (int m = 1; m <= 4; m++) begin
            logic [17:0] v;
            v = VEC[m];
            pulse_req(3'(m));
            chk("R4 sr_req first", 32'(sr_req), 1);
            chk("R4 osc untouched", 32'(osc_en), 1);
            chk("R4 dom untouched", 32'(dom_en), 32'hF);
            wait_idle("R3");
            chk_mode(m, "R3");
            repeat (3) @(negedge clk);
            chk("R5 sr held", 32'(sr_req), 1);
            pulse_wake();
            chk("R6 dom first", 32'(dom_en), 32'hF);
            chk("R6 osc unchanged", 32'(osc_en), 32'(v[10]));
            chk("R6 sr still", 32'(sr_req), 1);
            @(negedge clk);
            chk("R6 osc next", 32'(osc_en), 1);
            chk("R6 sr kept", 32'(sr_req), 1);
            wait_idle("R6");
            chk_mode(5, "R6");
            chk("R6 sr released", 32'(sr_req), 0);
        end

        // Held request
        pulse_req(3'd1);
        pulse_req(3'd2);
        wait_idle("R8");
        chk("R8 first served", 32'(mode), 1);
        pulse_wake();
        wait_idle("R8");
        @(negedge clk);
        chk("R8 held starts", 32'(busy), 1);
        wait_idle("R8");
        chk("R8 held mode", 32'(mode), 2);
        pulse_wake();
        wait_idle("R8");

        // Timeout boundary: ack visible on the 3rd wait cycle
        timeout = 8'd2;
        pulse_req(3'd3);
        wait_idle("R9");
        chk("R9 err set", 32'(err), 1);
        chk("R9 back active", 32'(mode), 5);
        chk("R9 dom on", 32'(dom_en), 32'hF);
        chk("R9 sr dropped", 32'(sr_req), 0);
        repeat (4) @(negedge clk);
        timeout = 8'd3;
        pulse_req(3'd3);
        chk("R9 err cleared", 32'(err), 0);
        wait_idle("R9");
        chk("R9 limit met", 32'(mode), 3);
        pulse_wake();
        wait_idle("R9");

        // Memory controller silent
        mem_ok = 1'b0;
        timeout = 8'd5;
        pulse_req(3'd4);
        wait_idle("R9");
        chk("R9 no ack err", 32'(err), 1);
        chk("R9 no ack osc", 32'(osc_en), 1);
        mem_ok = 1'b1;
        timeout = 8'd20;

        // RTC-only: wakeup ignored
        pulse_req(3'd0);
        wait_idle("R7");
        chk_mode(0, "R3 rtc");
        chk("R5 rtc sr", 32'(sr_req), 1);
        pulse_wake();
        repeat (4) @(negedge clk);
        chk("R7 mode", 32'(mode), 0);
        chk("R7 busy", 32'(busy), 0);
        chk("R7 dom", 32'(dom_en), 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mode(5, "R1 after rtc");
        summary();
    end
endmodule